// File: doc/BRIEF.md
# Command Method Dispatcher with Macro Capture

This block sits behind a command-stream parser and takes one method write per accepted transfer. A write carries a method index, a 32-bit value and a count of parameters still to follow in the same burst. The method index picks one of two paths. Indices below the macro boundary (0xE00) are plain register writes. They update a shadow register word and raise a one-cycle side-effect strobe that names the method, so that neighbouring logic can react. Indices from the boundary up to the end of the method space trigger macros. Their values are gathered into a parameter buffer. When the burst ends, the block presents a macro-call request carrying the macro entry, its method id and the collected parameters.

Macro entry n owns two slots. The even slot 0xE00+2n opens a call, and the odd slot that follows it streams further arguments. The block enforces this sequence. It also rejects indices outside the method space and records each kind of violation in its own sticky error bit, which stays set until `err_clr` is asserted. A rejected write changes nothing else.

Both data paths are valid/ready. A method write is taken when `in_valid` and `in_ready` are both high. `in_ready` drops for as long as a call request is pending. A request is pending from the cycle `call_valid` rises until the cycle it is taken with `call_ready`. During that time `call_entry`, `call_method`, `call_count` and the parameter buffer (read through `call_ridx`/`call_rdata`) are held. A producer may therefore keep `in_valid` high through back-pressure without losing or duplicating a write.

Top module: `mthd_dispatch`

## Requirements
- R1: A write with method index at or above the method-space size (0xE40) sets `err_range`, produces no strobe, no register update and no call, and does not disturb a capture in progress.
- R2: An accepted write with index below 0xE00 outside a capture stores the value: for indices below 64 the new value reads back on `rd_data` from the cycle after acceptance. `stb_valid` is high for exactly that one cycle, with `stb_method` equal to the index.
- R3: Outside a capture, a write to an even index 0xE00+2n opens a capture for entry n, and its value becomes parameter 0.
- R4: Outside a capture, a write to an odd index at or above 0xE00 sets `err_odd` and opens no capture and no call.
- R5: During a capture, any write whose index is not the opening index plus one sets `err_seq` and is dropped: no strobe, no register update, no parameter. The capture stays open.
- R6: Parameters are kept in arrival order. Parameter i is read on `call_rdata` with `call_ridx` = i, and `call_count` gives how many were kept.
- R7: A macro-slot write accepted with `in_remain` = 0 raises `call_valid` in the next cycle with `call_entry` = n and `call_method` = 0xE00+2n, and the block returns to idle. This includes a call opened and closed by a single write.
- R8: The parameter buffer holds 32 words. Any further value in the same capture sets `err_ovf` and is dropped, and `call_count` stays at 32.
- R9: `call_valid` and its payload are held until a cycle with `call_ready` high, after which `call_valid` falls. `in_ready` is low while `call_valid` is high, and a write offered then has no effect.
- R10: Each error bit stays set until `err_clr` is high. In a cycle where a new error and `err_clr` coincide, the bit ends up set.
- R11: While reset is held and right after it, `in_ready` is 1, and `stb_valid`, `call_valid`, all error bits and every shadow register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Method write offered |
| in_ready | output | 1 | Method write can be taken |
| in_method | input | 13 | Method index |
| in_data | input | 32 | Method value |
| in_remain | input | 8 | Parameters still to follow in this burst |
| stb_valid | output | 1 | One-cycle side-effect strobe for a plain write |
| stb_method | output | 13 | Index of the plain write being strobed |
| rd_idx | input | 6 | Shadow register read index |
| rd_data | output | 32 | Shadow register read data |
| call_valid | output | 1 | Macro-call request pending |
| call_ready | input | 1 | Consumer takes the macro-call request |
| call_entry | output | 5 | Macro entry number n |
| call_method | output | 13 | Opening method index of the call |
| call_count | output | 6 | Number of parameters kept |
| call_ridx | input | 5 | Parameter read index |
| call_rdata | output | 32 | Parameter word at `call_ridx` |
| err_clr | input | 1 | Clears all sticky error bits |
| err_range | output | 1 | Sticky: index outside method space |
| err_odd | output | 1 | Sticky: capture opened on an odd slot |
| err_seq | output | 1 | Sticky: out-of-sequence write during a capture |
| err_ovf | output | 1 | Sticky: parameter buffer overflow |

## Verification
The hardest state to reach from the ports is an overflowing capture that still closes cleanly. Getting there takes one opening write and then more than 32 continuation writes, with the remaining-count falling to zero only at the end. The stimulus streams 35 values with a decreasing count. It then checks that the error bit is set, that the count is held at 32 and that the last kept word is the 32nd value sent. A second corner is the coincidence of a new error with `err_clr`. The stimulus reaches it by driving an out-of-range write and the clear in the same cycle.

// File: rtl/mdd_pkg.sv
package mdd_pkg;
  localparam int METHOD_W = 13;
  localparam int WORD_W   = 32;

  localparam int ERR_N     = 4;
  localparam int ERR_RANGE = 0;
  localparam int ERR_ODD   = 1;
  localparam int ERR_SEQ   = 2;
  localparam int ERR_OVF   = 3;

  typedef enum logic [2:0] {
    WK_IDLE,
    WK_PLAIN,
    WK_OPEN,
    WK_APPEND,
    WK_BAD_RANGE,
    WK_BAD_ODD,
    WK_BAD_SEQ
  } wr_kind_e;
endpackage

// File: rtl/mdd_decode.sv
module mdd_decode
  import mdd_pkg::*;
#(
  parameter int NUM_METHODS = 3648,
  parameter int MACRO_BASE  = 3584
) (
  input  logic                acc,
  input  logic [METHOD_W-1:0] method,
  input  logic                busy,
  input  logic [METHOD_W-1:0] active_method,
  output wr_kind_e            kind
);
  localparam logic [METHOD_W-1:0] LIMIT = METHOD_W'(NUM_METHODS);
  localparam logic [METHOD_W-1:0] BASE  = METHOD_W'(MACRO_BASE);

  always_comb begin
    kind = WK_IDLE;
    if (acc) begin
      if (method >= LIMIT)                         kind = WK_BAD_RANGE;
      else if (busy)                               kind = (method == active_method + 1'b1) ? WK_APPEND : WK_BAD_SEQ;
      else if (method >= BASE)                     kind = method[0] ? WK_BAD_ODD : WK_OPEN;
      else                                         kind = WK_PLAIN;
    end
  end
endmodule

// File: rtl/mdd_regfile.sv
module mdd_regfile
  import mdd_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [METHOD_W-1:0] idx,
  input  logic [WORD_W-1:0]   data,
  input  logic [AW-1:0]       rd_idx,
  output logic [WORD_W-1:0]   rd_data,
  output logic                stb_valid,
  output logic [METHOD_W-1:0] stb_method
);
  logic [WORD_W-1:0] words [DEPTH];
  logic              hit;

  assign hit     = we && (idx < METHOD_W'(DEPTH));
  assign rd_data = words[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) words[i] <= '0;
    end else if (hit) begin
      words[idx[AW-1:0]] <= data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_valid  <= 1'b0;
      stb_method <= '0;
    end else begin
      stb_valid <= we;
      if (we) stb_method <= idx;
    end
  end

  AST_STB_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    stb_valid |-> $past(we)) else $error("strobe without plain write"); // R2
endmodule

// File: rtl/mdd_capture.sv
module mdd_capture
  import mdd_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int PB_AW = 5,
  parameter int CNT_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  wr_kind_e            kind,
  input  logic [METHOD_W-1:0] method,
  input  logic [WORD_W-1:0]   data,
  input  logic                last,
  input  logic                call_ready,
  input  logic [PB_AW-1:0]    ridx,
  output logic                busy,
  output logic [METHOD_W-1:0] active_method,
  output logic                call_valid,
  output logic [CNT_W-1:0]    call_count,
  output logic [WORD_W-1:0]   rdata,
  output logic                ovf_pulse
);
  logic [WORD_W-1:0] pbuf [DEPTH];
  logic              open_w, take_w, room_w;
  logic [CNT_W-1:0]  base_cnt;

  assign open_w    = (kind == WK_OPEN);
  assign take_w    = open_w || (kind == WK_APPEND);
  assign base_cnt  = open_w ? '0 : call_count;
  assign room_w    = base_cnt < CNT_W'(DEPTH);
  assign ovf_pulse = take_w && !room_w;
  assign rdata     = pbuf[ridx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy          <= 1'b0;
      active_method <= '0;
      call_valid    <= 1'b0;
      call_count    <= '0;
    end else begin
      if (open_w) active_method <= method;
      if (take_w) call_count <= room_w ? base_cnt + 1'b1 : base_cnt;
      if (take_w && last) begin
        busy       <= 1'b0;
        call_valid <= 1'b1;
      end else if (open_w) begin
        busy <= 1'b1;
      end else if (call_valid && call_ready) begin
        call_valid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) pbuf[i] <= '0;
    end else if (take_w && room_w) begin
      pbuf[base_cnt[PB_AW-1:0]] <= data;
    end
  end

  AST_PENDING_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    call_valid |-> !busy) else $error("capture open while call pending"); // R7
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    call_count <= CNT_W'(DEPTH)) else $error("parameter count beyond buffer"); // R8
  AST_CALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    call_valid && !call_ready |=> call_valid && $stable(active_method) && $stable(call_count))
    else $error("call request dropped or changed"); // R9
  AST_OPEN_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !active_method[0]) else $error("capture opened on odd slot"); // R4
endmodule

// File: rtl/mdd_errlog.sv
module mdd_errlog
  import mdd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_N-1:0] set,
  input  logic             clr,
  output logic [ERR_N-1:0] q
);
  for (genvar g = 0; g < ERR_N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[g] <= 1'b0;
      else if (set[g]) q[g] <= 1'b1;
      else if (clr)    q[g] <= 1'b0;
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      q[g] && !clr |=> q[g]) else $error("error bit lost without clear"); // R10
  end
endmodule

// File: rtl/mthd_dispatch.sv
module mthd_dispatch
  import mdd_pkg::*;
#(
  parameter int NUM_METHODS = 3648,
  parameter int MACRO_BASE  = 3584,
  parameter int REG_DEPTH   = 64,
  parameter int PBUF_DEPTH  = 32,
  parameter int REM_W       = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [12:0]         in_method,
  input  logic [31:0]         in_data,
  input  logic [REM_W-1:0]    in_remain,
  output logic                stb_valid,
  output logic [12:0]         stb_method,
  input  logic [$clog2(REG_DEPTH)-1:0] rd_idx,
  output logic [31:0]         rd_data,
  output logic                call_valid,
  input  logic                call_ready,
  output logic [$clog2((NUM_METHODS-MACRO_BASE)/2)-1:0] call_entry,
  output logic [12:0]         call_method,
  output logic [$clog2(PBUF_DEPTH+1)-1:0] call_count,
  input  logic [$clog2(PBUF_DEPTH)-1:0] call_ridx,
  output logic [31:0]         call_rdata,
  input  logic                err_clr,
  output logic                err_range,
  output logic                err_odd,
  output logic                err_seq,
  output logic                err_ovf
);
  localparam int RD_AW = $clog2(REG_DEPTH);
  localparam int PB_AW = $clog2(PBUF_DEPTH);
  localparam int CNT_W = $clog2(PBUF_DEPTH + 1);
  localparam int ENT_W = $clog2((NUM_METHODS - MACRO_BASE) / 2);

  logic                acc, busy, ovf_pulse;
  logic [METHOD_W-1:0] active_method, slot_off;
  wr_kind_e            kind;
  logic [ERR_N-1:0]    err_set, err_q;

  assign in_ready = !call_valid;
  assign acc      = in_valid && in_ready;

  mdd_decode #(.NUM_METHODS(NUM_METHODS), .MACRO_BASE(MACRO_BASE)) u_decode (
    .acc(acc), .method(in_method), .busy(busy),
    .active_method(active_method), .kind(kind)
  );

  mdd_regfile #(.DEPTH(REG_DEPTH), .AW(RD_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(kind == WK_PLAIN), .idx(in_method),
    .data(in_data), .rd_idx(rd_idx), .rd_data(rd_data),
    .stb_valid(stb_valid), .stb_method(stb_method)
  );

  mdd_capture #(.DEPTH(PBUF_DEPTH), .PB_AW(PB_AW), .CNT_W(CNT_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .kind(kind), .method(in_method), .data(in_data),
    .last(in_remain == '0), .call_ready(call_ready), .ridx(call_ridx),
    .busy(busy), .active_method(active_method), .call_valid(call_valid),
    .call_count(call_count), .rdata(call_rdata), .ovf_pulse(ovf_pulse)
  );

  assign slot_off    = active_method - METHOD_W'(MACRO_BASE);
  assign call_entry  = slot_off[ENT_W:1];
  assign call_method = active_method;

  assign err_set[ERR_RANGE] = (kind == WK_BAD_RANGE);
  assign err_set[ERR_ODD]   = (kind == WK_BAD_ODD);
  assign err_set[ERR_SEQ]   = (kind == WK_BAD_SEQ);
  assign err_set[ERR_OVF]   = ovf_pulse;

  mdd_errlog u_errs (
    .clk(clk), .rst_n(rst_n), .set(err_set), .clr(err_clr), .q(err_q)
  );

  assign err_range = err_q[ERR_RANGE];
  assign err_odd   = err_q[ERR_ODD];
  assign err_seq   = err_q[ERR_SEQ];
  assign err_ovf   = err_q[ERR_OVF];

  AST_RANGE_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_method >= 13'(NUM_METHODS)) |=> !stb_valid && $rose(err_range) || err_range)
    else $error("out-of-range write had an effect"); // R1
endmodule

// File: tb/mthd_dispatch_test.sv
module mthd_dispatch_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [12:0] in_method = '0;
  logic [31:0] in_data = '0;
  logic [7:0]  in_remain = '0;
  logic        stb_valid;
  logic [12:0] stb_method;
  logic [5:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic        call_valid;
  logic        call_ready = 1'b0;
  logic [4:0]  call_entry;
  logic [12:0] call_method;
  logic [5:0]  call_count;
  logic [4:0]  call_ridx = '0;
  logic [31:0] call_rdata;
  logic        err_clr = 1'b0;
  logic        err_range, err_odd, err_seq, err_ovf;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mthd_dispatch uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_method(in_method), .in_data(in_data), .in_remain(in_remain),
    .stb_valid(stb_valid), .stb_method(stb_method), .rd_idx(rd_idx), .rd_data(rd_data),
    .call_valid(call_valid), .call_ready(call_ready), .call_entry(call_entry),
    .call_method(call_method), .call_count(call_count), .call_ridx(call_ridx),
    .call_rdata(call_rdata), .err_clr(err_clr), .err_range(err_range),
    .err_odd(err_odd), .err_seq(err_seq), .err_ovf(err_ovf)
  );

  // each entry: {method[12:0], value[31:0]}
  localparam logic [44:0] VEC [6] = '{
    {13'h000, 32'hA5A5_A5A5},
    {13'h03F, 32'h1234_5678},
    {13'h010, 32'hDEAD_BEEF},
    {13'h010, 32'h0BAD_F00D},
    {13'h100, 32'hCAFE_F00D},
    {13'hDFF, 32'h1111_2222}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [12:0] m, input logic [31:0] d, input logic [7:0] r);
    @(negedge clk);
    in_valid = 1'b1; in_method = m; in_data = d; in_remain = r;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic rd_reg(input logic [5:0] i, input logic [31:0] exp, input string req);
    rd_idx = i; #1;
    chk(req, rd_data, exp);
  endtask

  task automatic rd_par(input logic [4:0] i, input logic [31:0] exp, input string req);
    call_ridx = i; #1;
    chk(req, call_rdata, exp);
  endtask

  task automatic take_call();
    @(negedge clk); call_ready = 1'b1;
    @(negedge clk); call_ready = 1'b0;
    chk("R9 call_valid after take", {31'd0, call_valid}, 32'd0);
    chk("R9 in_ready after take", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic clear_errs();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    chk("R10 cleared", {28'd0, err_range, err_odd, err_seq, err_ovf}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: values while reset is held
    chk("R11 in_ready in reset", {31'd0, in_ready}, 32'd1);
    chk("R11 call_valid in reset", {31'd0, call_valid}, 32'd0);
    chk("R11 stb_valid in reset", {31'd0, stb_valid}, 32'd0);
    chk("R11 errors in reset", {28'd0, err_range, err_odd, err_seq, err_ovf}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    rd_reg(6'h10, 32'd0, "R11 shadow word after reset");

    // R2: plain writes from the table
    for (int k = 0; k < 6; k++) begin
      wr(VEC[k][44:32], VEC[k][31:0], 8'd0);
      chk("R2 strobe high", {31'd0, stb_valid}, 32'd1);
      chk("R2 strobe method", {19'd0, stb_method}, {19'd0, VEC[k][44:32]});
      if (VEC[k][44:32] < 13'd64) rd_reg(VEC[k][37:32], VEC[k][31:0], "R2 readback");
      @(negedge clk);
      chk("R2 strobe one cycle", {31'd0, stb_valid}, 32'd0);
    end
    rd_reg(6'h10, 32'h0BAD_F00D, "R2 overwrite kept last");

    // R3 R6 R7: entry 3, three parameters
    wr(13'hE06, 32'd100, 8'd2);
    chk("R3 no call while open", {31'd0, call_valid}, 32'd0);
    wr(13'hE07, 32'd101, 8'd1);
    wr(13'hE07, 32'd102, 8'd0);
    chk("R7 call raised", {31'd0, call_valid}, 32'd1);
    chk("R7 entry", {27'd0, call_entry}, 32'd3);
    chk("R7 method", {19'd0, call_method}, 32'hE06);
    chk("R6 count", {26'd0, call_count}, 32'd3);
    rd_par(5'd0, 32'd100, "R3 first param");
    rd_par(5'd1, 32'd101, "R6 param 1");
    rd_par(5'd2, 32'd102, "R6 param 2");
    chk("R9 in_ready low", {31'd0, in_ready}, 32'd0);
    wr(13'h020, 32'h5555_0000, 8'd0);
    chk("R9 blocked write no strobe", {31'd0, stb_valid}, 32'd0);
    chk("R9 call held", {31'd0, call_valid}, 32'd1);
    rd_reg(6'h20, 32'd0, "R9 blocked write not stored");
    take_call();

    // R4: odd first write
    wr(13'hE09, 32'd5, 8'd0);
    chk("R4 err_odd", {31'd0, err_odd}, 32'd1);
    chk("R4 no call", {31'd0, call_valid}, 32'd0);
    @(negedge clk);
    chk("R10 sticky", {31'd0, err_odd}, 32'd1);
    clear_errs();

    // R5: out-of-sequence during capture
    wr(13'hE10, 32'd7, 8'd3);
    wr(13'hE12, 32'd8, 8'd2);
    chk("R5 err_seq wrong slot", {31'd0, err_seq}, 32'd1);
    wr(13'h005, 32'd9, 8'd0);
    chk("R5 plain write no strobe", {31'd0, stb_valid}, 32'd0);
    rd_reg(6'h05, 32'd0, "R5 plain write dropped");
    chk("R5 still open, no call", {31'd0, call_valid}, 32'd0);
    wr(13'hE11, 32'd10, 8'd0);
    chk("R5 call after recovery", {31'd0, call_valid}, 32'd1);
    chk("R5 entry", {27'd0, call_entry}, 32'd8);
    chk("R5 count", {26'd0, call_count}, 32'd2);
    rd_par(5'd1, 32'd10, "R5 dropped value not kept");
    take_call();
    clear_errs();

    // R1: out of range
    wr(13'hE40, 32'd1, 8'd0);
    chk("R1 err_range", {31'd0, err_range}, 32'd1);
    chk("R1 no strobe", {31'd0, stb_valid}, 32'd0);
    wr(13'h1FFF, 32'd2, 8'd0);
    chk("R1 no call", {31'd0, call_valid}, 32'd0);
    chk("R1 no other error", {29'd0, err_odd, err_seq, err_ovf}, 32'd0);
    clear_errs();

    // R8: overflow, 35 values
    wr(13'hE00, 32'h200, 8'd34);
    for (int k = 1; k < 35; k++) wr(13'hE01, 32'h200 + k, 8'(34 - k));
    chk("R8 err_ovf", {31'd0, err_ovf}, 32'd1);
    chk("R8 count capped", {26'd0, call_count}, 32'd32);
    chk("R8 entry", {27'd0, call_entry}, 32'd0);
    rd_par(5'd31, 32'h200 + 31, "R8 last kept word");
    rd_par(5'd0, 32'h200, "R8 first word");
    take_call();
    clear_errs();

    // R7: single-write call on last entry
    wr(13'hE3E, 32'h77, 8'd0);
    chk("R7 single call", {31'd0, call_valid}, 32'd1);
    chk("R7 single entry", {27'd0, call_entry}, 32'd31);
    chk("R7 single count", {26'd0, call_count}, 32'd1);
    rd_par(5'd0, 32'h77, "R7 single param");
    take_call();

    // R10: set and clear together
    @(negedge clk);
    in_valid = 1'b1; in_method = 13'hE41; in_remain = 8'd0; err_clr = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; err_clr = 1'b0;
    chk("R10 set wins", {31'd0, err_range}, 32'd1);
    clear_errs();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule